// File: doc/BRIEF.md
# BCD Calendar Counter with Access Freeze

This block keeps wall-clock time and date in packed BCD fields: seconds, minutes, hours, day of month, weekday, month and a two-digit year. A one-cycle `tick_1hz` pulse advances the time by one second. Carries ripple through the fields: day-of-month length depends on the month, and February gains a 29th day in leap years. Hours run in either 24-hour form or 12-hour form with a PM flag, selected by `use_12h`.

A host reads and writes the fields through a small register port. While `host_open` is high an access is in progress, and the counters are frozen. A tick that arrives during the access is held as a single pending advance and is applied once the access closes. Further ticks during the same access are lost. `hold_base` stops the time base so the host can load a time and release it on an exact second boundary. An oscillator-loss flag sits in the top bit of the seconds byte.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 0x80 (oscillator-loss flag set, seconds 00), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01 and year 0x00.
- R2: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R3: With `use_12h` low, hours count 00 to 23 in BCD, and the step from 23 to 00 advances the day.
- R4: With `use_12h` high, hours byte bit 5 is the PM flag and bits 4:0 hold 01 to 12 in BCD. 11 steps to 12 and toggles PM, 12 steps to 01, and the step from 11 PM to 12 AM advances the day.
- R5: Day of month wraps to 01 after its last day. That is 31, or 30 for months 04, 06, 09 and 11, or 28 for month 02. February has 29 days when the BCD year is divisible by 4, including 00. Month wraps from 12 to 01 and carries into the year, and the year wraps from 99 to 00.
- R6: Weekday counts 0 to 6 and steps once on each day advance, wrapping 6 to 0.
- R7: While `host_open` is high, no tick changes any time field. One tick seen during the access is applied in the first cycle with `host_open` low, and any further ticks in that access are dropped.
- R8: While `hold_base` is high, ticks have no effect on any time field, and any pending advance is discarded.
- R9: Seconds byte bit 7 is the oscillator-loss flag. `osc_lost` sets it. A host write to address 0 loads it from data bit 7, and `osc_lost` wins when both happen in the same cycle.
- R10: A host write loads the field directly without range checks. A value above the field's maximum wraps to the field's minimum at the next increment, with carry.
- R11: Address map: 0 seconds, 1 minutes, 2 hours, 3 day, 4 weekday, 5 month, 6 year, 7 reads 0x00. Field widths are 7, 7, 6, 6, 3, 5 and 8 bits, and unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| hold_base | input | 1 | Holds the time base while high |
| osc_lost | input | 1 | Sets the oscillator-loss flag |
| use_12h | input | 1 | 1 selects 12-hour format |
| host_open | input | 1 | Host access in progress |
| host_wr | input | 1 | Write strobe, valid with host_open |
| host_addr | input | 3 | Field address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |

## Verification
The assertions check, on every cycle, a set of local rules. The fields hold still during an open read-only access and under hold. A pending tick lands in the cycle after an access closes. Seconds wrap from 59 and carry into minutes. The PM flag flips on the 11-to-12 step, and a loss event sets the flag. Only the bench scenarios can show that whole calendar paths come out right, because those depend on sequences across many fields. These paths include month lengths, leap years such as year 00 and the century wrap, weekday wrap, the single-pending limit and wrapping after an out-of-range write.

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       hold_base,
  input  logic       osc_lost,
  input  logic       use_12h,
  input  logic       host_open,
  input  logic       host_wr,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);

  logic       osc_q, pend_q;
  logic [7:0] sec_q, min_q, hr_q, day_q, wday_q, mon_q, yr_q;

  function automatic logic [7:0] bcd_up(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic wen, adv;
  assign wen = host_open && host_wr;
  assign adv = !host_open && !hold_base && (tick_1hz || pend_q);

  logic sec_wrap, min_wrap, min_step, hr_step, day_step, mon_step, yr_step;
  assign sec_wrap = sec_q >= 8'h59;
  assign min_wrap = min_q >= 8'h59;
  assign min_step = adv && sec_wrap;
  assign hr_step  = min_step && min_wrap;

  logic [7:0] h12, hr_next12, hr_next24;
  logic       carry12, carry24;
  assign h12       = {3'b000, hr_q[4:0]};
  assign carry12   = (h12 == 8'h11) && hr_q[5];
  assign hr_next12 = (h12 == 8'h11) ? {2'b00, ~hr_q[5], 5'h12} :
                     (h12 >= 8'h12) ? {2'b00, hr_q[5], 5'h01} :
                     {2'b00, hr_q[5], 5'h00} | bcd_up(h12);
  assign carry24   = hr_q >= 8'h23;
  assign hr_next24 = carry24 ? 8'h00 : bcd_up(hr_q);
  assign day_step  = hr_step && (use_12h ? carry12 : carry24);

  logic       leap, short_mon;
  logic [7:0] last_day;
  assign leap      = yr_q[4] ? (yr_q[3:0] == 4'd2 || yr_q[3:0] == 4'd6)
                             : (yr_q[3:0] == 4'd0 || yr_q[3:0] == 4'd4 || yr_q[3:0] == 4'd8);
  assign short_mon = (mon_q == 8'h04) || (mon_q == 8'h06) || (mon_q == 8'h09) || (mon_q == 8'h11);
  assign last_day  = (mon_q == 8'h02) ? (leap ? 8'h29 : 8'h28) : short_mon ? 8'h30 : 8'h31;
  assign mon_step  = day_step && (day_q >= last_day);
  assign yr_step   = mon_step && (mon_q >= 8'h12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q <= 1'b1;
    end else if (osc_lost) begin
      osc_q <= 1'b1;
    end else if (wen && host_addr == 3'd0) begin
      osc_q <= host_wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= 1'b0;
    else if (hold_base)  pend_q <= 1'b0;
    else if (host_open)  pend_q <= pend_q || tick_1hz;
    else                 pend_q <= pend_q && tick_1hz;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= 8'h00; min_q <= 8'h00; hr_q <= 8'h00; day_q <= 8'h01;
      wday_q <= 8'h00; mon_q <= 8'h01; yr_q <= 8'h00;
    end else if (wen) begin
      case (host_addr)
        3'd0: sec_q  <= {1'b0, host_wdata[6:0]};
        3'd1: min_q  <= {1'b0, host_wdata[6:0]};
        3'd2: hr_q   <= {2'b00, host_wdata[5:0]};
        3'd3: day_q  <= {2'b00, host_wdata[5:0]};
        3'd4: wday_q <= {5'b00000, host_wdata[2:0]};
        3'd5: mon_q  <= {3'b000, host_wdata[4:0]};
        3'd6: yr_q   <= host_wdata;
        default: ;
      endcase
    end else if (adv) begin
      sec_q <= sec_wrap ? 8'h00 : bcd_up(sec_q);
      if (min_step) min_q <= min_wrap ? 8'h00 : bcd_up(min_q);
      if (hr_step)  hr_q  <= use_12h ? hr_next12 : hr_next24;
      if (day_step) begin
        wday_q <= (wday_q >= 8'h06) ? 8'h00 : wday_q + 8'h01;
        day_q  <= (day_q >= last_day) ? 8'h01 : bcd_up(day_q);
      end
      if (mon_step) mon_q <= (mon_q >= 8'h12) ? 8'h01 : bcd_up(mon_q);
      if (yr_step)  yr_q  <= (yr_q >= 8'h99) ? 8'h00 : bcd_up(yr_q);
    end
  end

  always_comb begin
    case (host_addr)
      3'd0: host_rdata = {osc_q, sec_q[6:0]};
      3'd1: host_rdata = min_q;
      3'd2: host_rdata = hr_q;
      3'd3: host_rdata = day_q;
      3'd4: host_rdata = wday_q;
      3'd5: host_rdata = mon_q;
      3'd6: host_rdata = yr_q;
      default: host_rdata = 8'h00;
    endcase
  end

  logic [55:0] tv;
  assign tv = {sec_q, min_q, hr_q, day_q, wday_q, mon_q, yr_q};

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_open && !host_wr) |=> $stable(tv));
  assert_pending_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(host_open) && pend_q && !hold_base) |=> (tv != $past(tv)));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_base && !host_open) |=> $stable(tv));
  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sec_q == 8'h59) |=> (sec_q == 8'h00 && min_q != $past(min_q)));
  assert_pm_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_step && use_12h && hr_q[4:0] == 5'h11) |=> (hr_q[5] != $past(hr_q[5])));
  assert_osc_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    osc_lost |=> osc_q);

endmodule

// File: tb/test_rtc_bcd_calendar.sv
`timescale 1ns/100ps
module test_rtc_bcd_calendar;
  logic clk = 0, rst_n = 0;
  logic tick_1hz = 0, hold_base = 0, osc_lost = 0, use_12h = 0;
  logic host_open = 0, host_wr = 0;
  logic [2:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  int checks = 0, errors = 0;

  rtc_bcd_calendar i_rtc_bcd_calendar (.clk, .rst_n, .tick_1hz, .hold_base, .osc_lost,
    .use_12h, .host_open, .host_wr, .host_addr, .host_wdata, .host_rdata);

  always #2.5 clk = ~clk;

  // bench-side model built from the requirements
  int m_sec, m_min, m_hr, m_day, m_wd, m_mon, m_yr;
  bit m_osc, m_pm, m_pend;

  function automatic logic [7:0] i2b(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic int b2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] exp_byte(int a);
    logic [7:0] t;
    case (a)
      0: begin t = i2b(m_sec); return {m_osc, t[6:0]}; end
      1: return i2b(m_min);
      2: begin t = i2b(m_hr); return use_12h ? {2'b00, m_pm, t[4:0]} : {2'b00, t[5:0]}; end
      3: return i2b(m_day);
      4: return 8'(m_wd);
      5: return i2b(m_mon);
      6: return i2b(m_yr);
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_step();
    bit dc;
    dc = 0;
    if (m_sec >= 59) begin
      m_sec = 0;
      if (m_min >= 59) begin
        m_min = 0;
        if (use_12h) begin
          if (m_hr == 11) begin m_hr = 12; m_pm = !m_pm; dc = !m_pm; end
          else if (m_hr >= 12) m_hr = 1;
          else m_hr++;
        end else begin
          if (m_hr >= 23) begin m_hr = 0; dc = 1; end else m_hr++;
        end
      end else m_min++;
    end else m_sec++;
    if (dc) begin
      int last;
      m_wd = (m_wd >= 6) ? 0 : m_wd + 1;
      if (m_mon == 2) last = (m_yr % 4 == 0) ? 29 : 28;
      else if (m_mon == 4 || m_mon == 6 || m_mon == 9 || m_mon == 11) last = 30;
      else last = 31;
      if (m_day >= last) begin
        m_day = 1;
        if (m_mon >= 12) begin m_mon = 1; m_yr = (m_yr >= 99) ? 0 : m_yr + 1; end
        else m_mon++;
      end else m_day++;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_wd = 0; m_mon = 1; m_yr = 0;
      m_osc = 1; m_pm = 0; m_pend = 0;
    end else begin
      bit adv;
      if (osc_lost) m_osc = 1;
      else if (host_open && host_wr && host_addr == 0) m_osc = host_wdata[7];
      if (host_open && host_wr) begin
        case (host_addr)
          0: m_sec = b2i({1'b0, host_wdata[6:0]});
          1: m_min = b2i({1'b0, host_wdata[6:0]});
          2: if (use_12h) begin m_pm = host_wdata[5]; m_hr = b2i({3'b0, host_wdata[4:0]}); end
             else m_hr = b2i({2'b0, host_wdata[5:0]});
          3: m_day = b2i({2'b0, host_wdata[5:0]});
          4: m_wd = int'(host_wdata[2:0]);
          5: m_mon = b2i({3'b0, host_wdata[4:0]});
          6: m_yr = b2i(host_wdata);
          default: ;
        endcase
      end
      adv = !host_open && !hold_base && (tick_1hz || m_pend);
      if (hold_base) m_pend = 0;
      else if (host_open) m_pend = m_pend || tick_1hz;
      else m_pend = m_pend && tick_1hz;
      if (adv) m_step();
    end
  end

  task automatic chk(string tag, int a, logic [7:0] exp);
    host_addr = 3'(a);
    #0.1;
    checks++;
    if (host_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %0d got %h expected %h", tag, a, host_rdata, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < 8; a++) chk(tag, a, exp_byte(a));
  endtask

  task automatic wr(int a, logic [7:0] d);
    host_open = 1; host_wr = 1; host_addr = 3'(a); host_wdata = d;
    @(negedge clk);
    host_open = 0; host_wr = 0;
  endtask

  task automatic set_time(logic [7:0] y, mo, d, wd, h, mi, s);
    wr(6, y); wr(5, mo); wr(3, d); wr(4, wd); wr(2, h); wr(1, mi); wr(0, s);
  endtask

  task automatic ticks(int n);
    tick_1hz = 1;
    repeat (n) @(negedge clk);
    tick_1hz = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", 0, 8'h80); chk("R1", 1, 8'h00); chk("R1", 2, 8'h00); chk("R1", 3, 8'h01);
    chk("R1", 4, 8'h00); chk("R1", 5, 8'h01); chk("R1", 6, 8'h00); chk("R11", 7, 8'h00);

    // R2 R3 R5 R6: 23:59:58 on Feb 28, year 23
    set_time(8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h58);
    ticks(2);
    chk("R2", 0, 8'h00); chk("R2", 1, 8'h00); chk("R3", 2, 8'h00);
    chk("R5", 3, 8'h01); chk("R5", 5, 8'h03); chk("R6", 4, 8'h04);

    set_time(8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R5", 3, 8'h29); chk("R5", 5, 8'h02);
    wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59);
    ticks(1);
    chk("R5", 3, 8'h01); chk("R5", 5, 8'h03);

    set_time(8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R5", 3, 8'h29);

    set_time(8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R5", 6, 8'h00); chk("R5", 5, 8'h01); chk("R5", 3, 8'h01); chk("R6", 4, 8'h00);

    set_time(8'h21, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R5", 3, 8'h01); chk("R5", 5, 8'h05);

    // R4: 12-hour mode
    host_open = 1; host_wr = 1; use_12h = 1; host_addr = 2; host_wdata = 8'h11;
    @(negedge clk); host_open = 0; host_wr = 0;
    wr(1, 8'h59); wr(0, 8'h59);
    ticks(1);
    chk("R4", 2, 8'h32);
    wr(1, 8'h59); wr(0, 8'h59);
    ticks(1);
    chk("R4", 2, 8'h21);
    wr(3, 8'h10); wr(2, 8'h31); wr(1, 8'h59); wr(0, 8'h59);
    ticks(1);
    chk("R4", 2, 8'h12); chk("R4", 3, 8'h11);
    host_open = 1; host_wr = 1; use_12h = 0; host_addr = 2; host_wdata = 8'h05;
    @(negedge clk); host_open = 0; host_wr = 0;

    // R7: freeze and single pending tick
    wr(1, 8'h20); wr(0, 8'h10);
    host_open = 1; tick_1hz = 1;
    repeat (5) @(negedge clk);
    tick_1hz = 0;
    chk("R7", 0, 8'h10); chk("R7", 1, 8'h20);
    host_open = 0;
    @(negedge clk);
    chk("R7", 0, 8'h11);
    @(negedge clk);
    chk("R7", 0, 8'h11);

    // R8: hold
    hold_base = 1;
    ticks(4);
    chk("R8", 0, 8'h11);
    hold_base = 0;
    ticks(1);
    chk("R8", 0, 8'h12);

    // R9: oscillator-loss flag
    wr(0, 8'h05);
    chk("R9", 0, 8'h05);
    osc_lost = 1; @(negedge clk); osc_lost = 0;
    chk("R9", 0, 8'h85);
    osc_lost = 1; wr(0, 8'h07); osc_lost = 0;
    chk("R9", 0, 8'h87);
    wr(0, 8'h07);
    chk("R9", 0, 8'h07);

    // R10: out-of-range loads
    wr(1, 8'h10); wr(0, 8'h65);
    chk("R10", 0, 8'h65);
    ticks(1);
    chk("R10", 0, 8'h00); chk("R10", 1, 8'h11);
    wr(5, 8'h04); wr(3, 8'h35); wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59);
    ticks(1);
    chk("R10", 3, 8'h01); chk("R10", 5, 8'h05);
    check_all("R11");

    // random phase against the bench model
    void'($urandom(32'd1234));
    for (int ph = 0; ph < 2; ph++) begin
      host_open = 1; host_wr = 1; use_12h = ph[0]; host_addr = 2;
      host_wdata = ph[0] ? 8'h11 : 8'h22;
      @(negedge clk); host_open = 0; host_wr = 0;
      for (int i = 0; i < 2500; i++) begin
        int r, a;
        logic [7:0] v;
        r = int'($urandom % 100);
        tick_1hz = ($urandom % 3) != 0;
        hold_base = ($urandom % 40) == 0;
        osc_lost = ($urandom % 60) == 0;
        host_open = r < 25;
        host_wr = 0;
        if (r < 10) begin
          host_wr = 1;
          a = int'($urandom % 8);
          case (a)
            0, 1: v = i2b(int'($urandom % 80)) | {$urandom % 2 == 0, 7'h0};
            2: v = ph[0] ? {2'b00, 1'($urandom), 5'(i2b(int'($urandom % 20)))}
                         : i2b(int'($urandom % 40));
            3: v = i2b(int'($urandom % 40));
            4: v = 8'($urandom % 8);
            5: v = i2b(int'($urandom % 20));
            default: v = i2b(int'($urandom % 100));
          endcase
          if (a == 1 || a == 0) v = (r < 5) ? (v & 8'hF0) | 8'h09 : v;
          if (a == 0 && (r % 2 == 0)) v = {v[7], 7'h59};
          host_addr = 3'(a); host_wdata = v;
        end
        @(negedge clk);
        host_open = 0; host_wr = 0; osc_lost = 0;
        check_all(ph[0] ? "R4 R7 random" : "R2 R3 R5 R6 R8 random");
      end
      tick_1hz = 0; hold_base = 0;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule